// File: doc/BRIEF.md
# Quadrature Edge-Phase FSK Demodulator

This block turns two hard-limited baseband square waves from a zero-IF receiver into a binary data stream. The in-phase (I) and quadrature (Q) channels arrive unsynchronised. Each channel first passes through its own flop synchroniser. The block then watches for transitions on either channel.

Every transition on one channel takes the level of the other channel and decides which channel leads. When I lags Q, the received tone sits above the local oscillator. When I leads Q, the tone sits below it. Because each channel has two edges per IF cycle, a fresh decision is made four times per cycle. The worst-case timing jitter of the recovered data is therefore a quarter of an IF period.

A one-cycle strobe marks each new decision. A build-time option adds a three-tap majority vote over the most recent decisions. This vote removes isolated wrong decisions when the bit rate is low compared with the IF.

Top module: `qpd_demod`

## Requirements
- R1: While reset is held, and right after it is released, `data_o` is 0 and `strobe_o` is 0.
- R2: When only the synchronised I level changes, the new decision is 1 if the new I level equals the Q level, and 0 otherwise.
- R3: When only the synchronised Q level changes, the new decision is 1 if the new Q level differs from the I level, and 0 otherwise.
- R4: Suppose the channels rotate through the (I,Q) states 00, 01, 11, 10, so that Q leads and I lags. Then every decision is 1. Rotating the other way, 00, 10, 11, 01, makes every decision 0.
- R5: If I and Q both change in the same synchronised cycle, no decision is made. `strobe_o` stays 0 and `data_o` keeps its value.
- R6: When neither channel changes, `strobe_o` stays 0 and `data_o` keeps its value.
- R7: Suppose an input change is first sampled at rising edge 1. Its decision appears on `data_o` and `strobe_o` right after rising edge SYNC_STAGES+1 when MAJORITY_EN is 0. It appears one edge later when MAJORITY_EN is 1.
- R8: `strobe_o` is high for exactly one clock cycle for each decision.
- R9: With MAJORITY_EN set to 1, each strobe carries the majority of the three most recent decisions. The decision history starts at all zeros after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_lim | input | 1 | Limited in-phase square wave, asynchronous |
| q_lim | input | 1 | Limited quadrature square wave, asynchronous |
| data_o | output | 1 | Recovered data bit (1 = tone above the local oscillator) |
| strobe_o | output | 1 | One-cycle pulse on each new decision |

## Verification
The assertions look only at the synchronised channel levels and at the registered decision path. They therefore assume nothing about the analog edge rates. They do assume that each synchronised level is steady for long enough that an edge seen by the detector really is one transition. The stimulus changes the inputs only on falling clock edges. It then holds them for at least five cycles, so no pulse is lost in the synchroniser and each step gives exactly one decision, or none. The reset state has both channels low. This matches the synchroniser's reset value, so no spurious edge appears when reset is released.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
   typedef struct packed {
      logic i;
      logic q;
   } iq_t;

   typedef enum logic [1:0] {
      EK_NONE = 2'b00,
      EK_I    = 2'b10,
      EK_Q    = 2'b01,
      EK_BOTH = 2'b11
   } edge_kind_e;
endpackage

// File: rtl/qpd_sync.sv
module qpd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial assert (STAGES >= 2) else $error("qpd_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/qpd_phase_det.sv
module qpd_phase_det
   import qpd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  iq_t  now_iq,
   output logic dec_vld,
   output logic dec_bit
);
   iq_t        prev_iq;
   edge_kind_e kind;

   always_comb begin
      kind = edge_kind_e'({now_iq.i ^ prev_iq.i, now_iq.q ^ prev_iq.q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_iq <= '0;
         dec_vld <= 1'b0;
         dec_bit <= 1'b0;
      end else begin
         prev_iq <= now_iq;
         dec_vld <= (kind == EK_I) || (kind == EK_Q);
         case (kind)
            EK_I:    dec_bit <= (now_iq.i == now_iq.q);
            EK_Q:    dec_bit <= (now_iq.q != now_iq.i);
            default: dec_bit <= dec_bit;
         endcase
      end
   end

   // R2: a lone I transition yields a decision matching I against Q
   a_r2_i_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == EK_I) |=> (dec_vld && (dec_bit == $past(now_iq.i == now_iq.q))));

   // R3: a lone Q transition yields a decision of Q differing from I
   a_r3_q_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == EK_Q) |=> (dec_vld && (dec_bit == $past(now_iq.q != now_iq.i))));

   // R5: simultaneous transitions produce no decision and keep the bit
   a_r5_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == EK_BOTH) |=> (!dec_vld && $stable(dec_bit)));

   // R6: quiet inputs produce no decision
   a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == EK_NONE) |=> (!dec_vld && $stable(dec_bit)));
endmodule

// File: rtl/qpd_vote.sv
module qpd_vote #(
   parameter bit ENABLE = 1'b1,
   parameter int TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_vld,
   input  logic in_bit,
   output logic out_vld,
   output logic out_bit
);
   localparam int HALF = TAPS / 2;

   initial assert (TAPS >= 3 && (TAPS % 2) == 1)
      else $error("qpd_vote: TAPS must be odd and at least 3");

   if (ENABLE) begin : g_vote
      logic [TAPS-1:0] hist;
      logic [TAPS-1:0] next_hist;

      always_comb next_hist = {hist[TAPS-2:0], in_bit};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist    <= '0;
            out_vld <= 1'b0;
            out_bit <= 1'b0;
         end else begin
            out_vld <= in_vld;
            if (in_vld) begin
               hist    <= next_hist;
               out_bit <= ($countones(next_hist) > HALF);
            end
         end
      end

      // R8: each incoming decision gives exactly one outgoing strobe
      a_r8_vote_follow: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld);
      a_r8_vote_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> (!out_vld && $stable(out_bit)));
      // R9: a unanimous history must give the same bit out
      a_r9_unanimous: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && (next_hist == '1)) |=> out_bit);
   end else begin : g_pass
      assign out_vld = in_vld;
      assign out_bit = in_bit;
   end
endmodule

// File: rtl/qpd_demod.sv
module qpd_demod
   import qpd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY_EN = 1'b1,
   parameter int VOTE_TAPS   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic i_lim,
   input  logic q_lim,
   output logic data_o,
   output logic strobe_o
);
   iq_t  sync_iq;
   logic dec_vld;
   logic dec_bit;

   qpd_sync #(.STAGES(SYNC_STAGES)) u_sync_i (
      .clk(clk), .rst_n(rst_n), .d(i_lim), .q(sync_iq.i));

   qpd_sync #(.STAGES(SYNC_STAGES)) u_sync_q (
      .clk(clk), .rst_n(rst_n), .d(q_lim), .q(sync_iq.q));

   qpd_phase_det u_det (
      .clk(clk), .rst_n(rst_n), .now_iq(sync_iq),
      .dec_vld(dec_vld), .dec_bit(dec_bit));

   qpd_vote #(.ENABLE(MAJORITY_EN), .TAPS(VOTE_TAPS)) u_vote (
      .clk(clk), .rst_n(rst_n), .in_vld(dec_vld), .in_bit(dec_bit),
      .out_vld(strobe_o), .out_bit(data_o));

   // R1: outputs are idle while reset is applied
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_idle: assert (!strobe_o && !data_o);
      end
   end

   // R6: the output only moves together with a strobe
   a_r6_data_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_o |-> $stable(data_o));
endmodule

// File: tb/qpd_demod_bench.sv
module qpd_demod_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  SYNC       = 2;
   localparam int  LAT_RAW    = SYNC + 1;
   localparam int  LAT_VOTE   = SYNC + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic i_lim = 1'b0;
   logic q_lim = 1'b0;
   logic d_raw, s_raw, d_vote, s_vote;

   int checks = 0;
   int failures = 0;

   logic cur_i = 1'b0, cur_q = 1'b0;
   logic exp_raw = 1'b0, exp_vote = 1'b0;
   logic [2:0] hist = 3'b000;

   always #(CLK_PERIOD/2) clk = ~clk;

   qpd_demod #(.SYNC_STAGES(SYNC), .MAJORITY_EN(1'b0)) u_qpd_demod (
      .clk(clk), .rst_n(rst_n), .i_lim(i_lim), .q_lim(q_lim),
      .data_o(d_raw), .strobe_o(s_raw));

   qpd_demod #(.SYNC_STAGES(SYNC), .MAJORITY_EN(1'b1)) u_qpd_demod_vote (
      .clk(clk), .rst_n(rst_n), .i_lim(i_lim), .q_lim(q_lim),
      .data_o(d_vote), .strobe_o(s_vote));

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic ni, input logic nq, input string tag);
      logic ich, qch, upd, d;
      string t;
      ich = (ni != cur_i);
      qch = (nq != cur_q);
      upd = ich ^ qch;
      d   = ich ? (ni == nq) : (nq != ni);
      if (tag != "") t = tag;
      else if (ich && qch) t = "R5";
      else if (ich) t = "R2";
      else if (qch) t = "R3";
      else t = "R6";
      if (upd) begin
         exp_raw  = d;
         hist     = {hist[1:0], d};
         exp_vote = ($countones(hist) >= 2);
      end
      cur_i = ni;
      cur_q = nq;
      @(negedge clk);
      i_lim = ni;
      q_lim = nq;
      for (int c = 1; c <= 5; c++) begin
         @(posedge clk);
         #1;
         check("R7 R8 raw strobe", s_raw, upd && (c == LAT_RAW));
         check("R7 R8 voted strobe", s_vote, upd && (c == LAT_VOTE));
      end
      check({t, " raw data"}, d_raw, exp_raw);
      check({"R9 ", t, " voted data"}, d_vote, exp_vote);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 raw data in reset", d_raw, 1'b0);
      check("R1 raw strobe in reset", s_raw, 1'b0);
      check("R1 voted data in reset", d_vote, 1'b0);
      check("R1 voted strobe in reset", s_vote, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) begin
         @(posedge clk);
         #1;
         check("R1 raw strobe after reset", s_raw, 1'b0);
         check("R1 voted data after reset", d_vote, 1'b0);
      end

      // Exhaustive sweep: every start state to every target state
      for (int s = 0; s < 4; s++) begin
         for (int e = 0; e < 4; e++) begin
            step(s[1], s[0], "");
            step(e[1], e[0], "");
         end
      end

      // R4: Q leading (I lags) -> all ones; two full IF cycles
      step(1'b0, 1'b0, "");
      for (int k = 0; k < 8; k++) begin
         case (k % 4)
            0: step(1'b0, 1'b1, "R4");
            1: step(1'b1, 1'b1, "R4");
            2: step(1'b1, 1'b0, "R4");
            default: step(1'b0, 1'b0, "R4");
         endcase
      end
      // R4: I leading -> all zeros
      for (int k = 0; k < 8; k++) begin
         case (k % 4)
            0: step(1'b1, 1'b0, "R4");
            1: step(1'b1, 1'b1, "R4");
            2: step(1'b0, 1'b1, "R4");
            default: step(1'b0, 1'b0, "R4");
         endcase
      end
      // R9: isolated reversal inside a run of ones
      step(1'b0, 1'b1, "");
      step(1'b1, 1'b1, "");
      step(1'b1, 1'b0, "");
      step(1'b1, 1'b1, "R9");
      step(1'b1, 1'b0, "R9");
      step(1'b0, 1'b0, "R9");
      // R5 and R6 from a known state
      step(1'b1, 1'b1, "R5");
      step(1'b1, 1'b1, "R6");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule